// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block multiplies two 32-bit operands and places the 64-bit result in a pair of 32-bit registers. HI holds the upper half and LO the lower half. It can also add the product to the 64-bit value already held in HI:LO, or subtract the product from it. Each of these three actions has a signed form and an unsigned form. The operands are sign-extended or zero-extended to 64 bits before the multiply.

A one-cycle start strobe with a valid operation code launches an iterative multiply. The multiply folds one slice of the extended second operand into a running partial sum on each clock, so a result takes a fixed number of cycles. While the unit works it raises busy. When the result lands in HI:LO it pulses done. Software-style moves into HI or LO use two separate write-enable ports. These loads are honoured only while the unit is idle.

Top module: `hilo_mac`

## Requirements
- R1: After reset, hi and lo are zero, and busy and done are low.
- R2: The operation code is 0 signed multiply, 1 unsigned multiply, 2 signed multiply-add, 3 unsigned multiply-add, 4 signed multiply-subtract, 5 unsigned multiply-subtract. A start with code 6 or 7 is ignored: busy stays low, done stays low and hi/lo keep their values.
- R3: Signed multiply sets {hi,lo} to the 64-bit product of both operands sign-extended to 64 bits. hi is bits 63:32 and lo is bits 31:0.
- R4: Unsigned multiply sets {hi,lo} to the product of both operands zero-extended to 64 bits.
- R5: Multiply-add (codes 2 and 3) sets {hi,lo} to the old {hi,lo} plus the product, modulo 2^64, and raises no flag.
- R6: Multiply-subtract (codes 4 and 5) sets {hi,lo} to the old {hi,lo} minus the product, modulo 2^64.
- R7: Busy rises on the clock edge that accepts a start and stays high for exactly 4 cycles. On the 4th edge after the accepting edge, busy falls, hi/lo take the result and done is high for that single cycle.
- R8: A start presented while busy is high is ignored. The running operation completes with its own operands and code.
- R9: While busy is low, hi_we loads hi_wdata into hi and lo_we loads lo_wdata into lo on the next edge, each independently of the other.
- R10: While busy is high, hi_we and lo_we are ignored. This includes the cycle in which the result is written.
- R11: A load presented in the same cycle as an accepted start takes effect, and the accumulating operation then uses the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe |
| op | input | 3 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| hi_we | input | 1 | Direct load enable for hi |
| hi_wdata | input | 32 | Direct load value for hi |
| lo_we | input | 1 | Direct load enable for lo |
| lo_wdata | input | 32 | Direct load value for lo |
| hi | output | 32 | Upper result register |
| lo | output | 32 | Lower result register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle. A direct load can coincide with the start of an operation, and it can also coincide with any cycle of a running operation, including the cycle that writes the result. The bench drives loads at the launch edge, in the middle of the run and on the completion edge. It also drives a second start in the middle of a run. It then judges the final hi/lo against a model in which only the launch-edge load counts and the stray start has no effect.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

  typedef enum logic [2:0] {
    OP_MUL_S = 3'd0,
    OP_MUL_U = 3'd1,
    OP_ADD_S = 3'd2,
    OP_ADD_U = 3'd3,
    OP_SUB_S = 3'd4,
    OP_SUB_U = 3'd5
  } mac_op_e;

  typedef enum logic [1:0] {
    MODE_SET = 2'd0,
    MODE_ADD = 2'd1,
    MODE_SUB = 2'd2
  } acc_mode_e;

  // codes 6 and 7 carry no operation
  function automatic logic op_valid(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

  // bits 2:1 of the code pick how the product meets HI:LO
  function automatic acc_mode_e mode_of(input logic [1:0] grp);
    case (grp)
      2'd0:    return MODE_SET;
      2'd1:    return MODE_ADD;
      default: return MODE_SUB;
    endcase
  endfunction

endpackage

// File: rtl/hilo_mac_ctrl.sv
module hilo_mac_ctrl
  import hilo_mac_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic [2:0] op,
  output logic      accept,
  output logic      busy,
  output logic      finish,
  output logic      done,
  output acc_mode_e mode
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;
  acc_mode_e     mode_q;

  assign accept = start && !busy_q && op_valid(op);
  assign finish = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      mode_q <= MODE_SET;
    end else begin
      done_q <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        mode_q <= mode_of(op[2:1]);
      end else if (busy_q) begin
        if (finish) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign mode = mode_q;
endmodule

// File: rtl/hilo_mac_mult.sv
module hilo_mac_mult #(
  parameter int W     = 32,
  parameter int STEPS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           advance,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod_next
);
  localparam int PW    = 2 * W;
  localparam int CHUNK = PW / STEPS;

  logic [PW-1:0] a_q, b_q, part_q;

  function automatic logic [PW-1:0] extend(input logic [W-1:0] x, input logic s);
    return s ? {{W{x[W-1]}}, x} : {{W{1'b0}}, x};
  endfunction

  // one slice of the multiplier operand times the shifted multiplicand
  function automatic logic [PW-1:0] slice_term(input logic [PW-1:0] mcand,
                                               input logic [CHUNK-1:0] slice);
    return mcand * PW'(slice);
  endfunction

  assign prod_next = part_q + slice_term(a_q, b_q[CHUNK-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      part_q <= '0;
    end else if (accept) begin
      a_q    <= extend(a, sgn);
      b_q    <= extend(b, sgn);
      part_q <= '0;
    end else if (advance) begin
      a_q    <= a_q << CHUNK;
      b_q    <= b_q >> CHUNK;
      part_q <= prod_next;
    end
  end
endmodule

// File: rtl/hilo_mac_acc.sv
module hilo_mac_acc
  import hilo_mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           finish,
  input  logic           busy,
  input  acc_mode_e      mode,
  input  logic [2*W-1:0] prod,
  input  logic           hi_we,
  input  logic [W-1:0]   hi_wdata,
  input  logic           lo_we,
  input  logic [W-1:0]   lo_wdata,
  output logic [W-1:0]   hi,
  output logic [W-1:0]   lo
);
  localparam int PW = 2 * W;

  logic [W-1:0] hi_q, lo_q;

  function automatic logic [PW-1:0] combine(input acc_mode_e m,
                                            input logic [PW-1:0] cur,
                                            input logic [PW-1:0] p);
    case (m)
      MODE_ADD: return cur + p;
      MODE_SUB: return cur - p;
      default:  return p;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (finish) begin
      {hi_q, lo_q} <= combine(mode, {hi_q, lo_q}, prod);
    end else if (!busy) begin
      if (hi_we) hi_q <= hi_wdata;
      if (lo_we) lo_q <= lo_wdata;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;
endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
  import hilo_mac_pkg::*;
#(
  parameter int W     = 32,
  parameter int STEPS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         hi_we,
  input  logic [W-1:0] hi_wdata,
  input  logic         lo_we,
  input  logic [W-1:0] lo_wdata,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         busy,
  output logic         done
);
  logic           accept;
  logic           finish;
  acc_mode_e      mode;
  logic [2*W-1:0] prod_next;

  hilo_mac_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .accept(accept), .busy(busy), .finish(finish), .done(done), .mode(mode)
  );

  hilo_mac_mult #(.W(W), .STEPS(STEPS)) u_mult (
    .clk(clk), .rst_n(rst_n), .accept(accept), .advance(busy),
    .sgn(~op[0]), .a(opa), .b(opb), .prod_next(prod_next)
  );

  hilo_mac_acc #(.W(W)) u_acc (
    .clk(clk), .rst_n(rst_n), .finish(finish), .busy(busy), .mode(mode),
    .prod(prod_next), .hi_we(hi_we), .hi_wdata(hi_wdata),
    .lo_we(lo_we), .lo_wdata(lo_wdata), .hi(hi), .lo(lo)
  );
endmodule

// File: rtl/hilo_mac_chk.sv
module hilo_mac_chk #(
  parameter int W     = 32,
  parameter int STEPS = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         accept,
  input logic         finish,
  input logic         busy,
  input logic         done,
  input logic         hi_we,
  input logic [W-1:0] hi_wdata,
  input logic         lo_we,
  input logic [W-1:0] lo_wdata,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int LW = $clog2(STEPS + 2) + 1;
  logic [LW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !busy && !done && hi == '0 && lo == '0); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy); // R7
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> run_len == LW'(STEPS)); // R7
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) run_len <= LW'(STEPS)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !accept); // R8
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy && !finish |=> $stable(hi) && $stable(lo)); // R10
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !busy && hi_we |=> hi == $past(hi_wdata)); // R9
  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !busy && lo_we |=> lo == $past(lo_wdata)); // R9
endmodule

bind hilo_mac hilo_mac_chk #(.W(W), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .finish(finish), .busy(busy),
  .done(done), .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we),
  .lo_wdata(lo_wdata), .hi(hi), .lo(lo)
);

// File: tb/hilo_mac_bench.sv
`timescale 1ns/1ps
module hilo_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opa = '0, opb = '0;
  logic        hi_we = 1'b0, lo_we = 1'b0;
  logic [31:0] hi_wdata = '0, lo_wdata = '0;
  logic [31:0] hi, lo;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  logic [63:0] model = '0;

  always #10 clk = ~clk;

  hilo_mac u_hilo_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi(hi), .lo(lo), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference arithmetic, written independently of the design
  function automatic logic [63:0] ref_result(input logic [2:0] o, input logic [31:0] a,
                                             input logic [31:0] b, input logic [63:0] cur);
    longint sa, sb;
    longint unsigned ua, ub, p;
    if (o[0] == 1'b0) begin
      sa = longint'(signed'(a));
      sb = longint'(signed'(b));
      p  = longint'(sa * sb);
    end else begin
      ua = {32'd0, a};
      ub = {32'd0, b};
      p  = ua * ub;
    end
    if (o < 3'd2)      return p;
    else if (o < 3'd4) return cur + p;
    else               return cur - p;
  endfunction

  // inj: 0 none, 1 second start mid-run (R8), 2 loads mid-run and on result edge (R10),
  //      3 loads together with the start (R11)
  task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input int inj, input logic [31:0] lh, input logic [31:0] ll, input string req);
    start = 1'b1; op = o; opa = a; opb = b;
    if (inj == 3) begin
      hi_we = 1'b1; lo_we = 1'b1; hi_wdata = lh; lo_wdata = ll;
      model = {lh, ll};
    end
    model = ref_result(o, a, b, model);
    @(negedge clk);
    start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      check(busy && !done, "R7 busy/done during run", {62'd0, busy, done}, 64'd2);
      start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
      if (inj == 1 && k == 2) begin
        start = 1'b1; op = 3'd1; opa = ~a; opb = b + 32'd3;
      end
      if (inj == 2 && (k == 2 || k == 4)) begin
        hi_we = 1'b1; lo_we = 1'b1; hi_wdata = ~lh; lo_wdata = ll ^ 32'h5a5a;
      end
      @(negedge clk);
    end
    start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    check(done && !busy, "R7 done at 4th edge", {62'd0, busy, done}, 64'd1);
    check({hi, lo} == model, req, {hi, lo}, model);
    @(negedge clk);
    check(!done, "R7 done is one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic do_load(input bit wh, input logic [31:0] h, input bit wl, input logic [31:0] l);
    hi_we = wh; lo_we = wl; hi_wdata = h; lo_wdata = l;
    if (wh) model[63:32] = h;
    if (wl) model[31:0] = l;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
    check({hi, lo} == model, "R9 direct load", {hi, lo}, model);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(hi == 0 && lo == 0, "R1 hi/lo reset", {hi, lo}, 64'd0);
    check(!busy && !done, "R1 busy/done reset", {62'd0, busy, done}, 64'd0);

    // R3 signed multiply corners
    run_op(3'd0, 32'hffffffff, 32'hffffffff, 0, 0, 0, "R3 -1*-1");
    run_op(3'd0, 32'h80000000, 32'h80000000, 0, 0, 0, "R3 min*min");
    run_op(3'd0, 32'd7, 32'hfffffffd, 0, 0, 0, "R3 7*-3");
    // R4 unsigned multiply
    run_op(3'd1, 32'hffffffff, 32'hffffffff, 0, 0, 0, "R4 max*max");
    run_op(3'd1, 32'h80000000, 32'd2, 0, 0, 0, "R4 carry into hi");

    // R9 independent loads
    do_load(1'b1, 32'h12345678, 1'b0, 32'hdead0000);
    do_load(1'b0, 32'hbeef0000, 1'b1, 32'h9abcdef0);
    do_load(1'b1, 32'hffffffff, 1'b1, 32'hffffffff);

    // R5 wrap on add, R6 wrap on subtract
    run_op(3'd3, 32'd1, 32'd1, 0, 0, 0, "R5 unsigned add wraps");
    run_op(3'd4, 32'd1, 32'd1, 0, 0, 0, "R6 signed sub wraps");
    run_op(3'd2, 32'hffffffff, 32'd5, 0, 0, 0, "R5 signed add negative product");
    run_op(3'd5, 32'hffffffff, 32'd2, 0, 0, 0, "R6 unsigned sub");

    // R2 invalid codes ignored
    for (int c = 6; c <= 7; c++) begin
      start = 1'b1; op = 3'(c); opa = 32'd9; opb = 32'd9;
      @(negedge clk);
      start = 1'b0;
      check(!busy, "R2 invalid code no busy", {63'd0, busy}, 64'd0);
      repeat (4) @(negedge clk);
      check(!done && {hi, lo} == model, "R2 invalid code no effect", {hi, lo}, model);
    end

    // R8 start while busy, R10 loads while busy, R11 load with start
    run_op(3'd0, 32'h00001234, 32'hffff0001, 1, 0, 0, "R8 second start ignored");
    run_op(3'd2, 32'h00000100, 32'h00000200, 2, 32'h11111111, 32'h22222222, "R10 load while busy ignored");
    run_op(3'd4, 32'h00000003, 32'h00000005, 3, 32'h00000001, 32'h00000000, "R11 load with start");
    run_op(3'd3, 32'hffffffff, 32'hffffffff, 3, 32'hffffffff, 32'h00000000, "R11 load with unsigned add");

    // random mix across all codes and occasional loads
    for (int i = 0; i < 60; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 3) == 0)
        do_load(1'b1, $urandom(), 1'b1, $urandom());
      run_op(o, $urandom(), $urandom(), int'($urandom_range(0, 3)), $urandom(), $urandom(),
             o < 3'd2 ? "R3/R4 random multiply" : (o < 3'd4 ? "R5 random add" : "R6 random sub"));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule